// File: doc/BRIEF.md
# UART interrupt status and routing

This block gathers the interrupt requests of a serial port into one sticky raw status vector of eleven bits. The bits come from the receive, transmit, receive-timeout, modem-status and error sources. Each source gives a one-cycle set pulse. A write to the transmit data register also sets the transmit bit. Software programs an enable mask. It clears raw bits by writing ones to a clear register. It can read back the raw status, the masked status and the mask.

The block drives six registered request lines. One is a combined line that is active when any enabled bit is pending. The other five each follow one category: receive, transmit, receive timeout, the modem-status group and the error group. Address decoding lives in the register interface next to the block. That interface hands over a write strobe, a register select, write data and a read select.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the raw status and the mask are zero, all six request lines are low and the read data is zero.
- R2: A set pulse on any bit of `src_set_i` makes that raw bit one. The bit stays one until it is cleared, and pulses on different bits accumulate. Bit map: 0 ring, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R3: A pulse on `data_wr_i` sets raw bit 5 (transmit).
- R4: A write with select 3 (clear) clears every raw bit whose write data bit is one. It leaves all other raw bits unchanged.
- R5: When a set pulse and a clear of the same bit land in the same cycle, the bit ends up one.
- R6: A write with select 0 loads the mask. Read select 0 returns the mask. Read select 1 returns the raw status. Read select 2 returns the raw status ANDed with the mask.
- R7: Writes with select 1 (raw) or select 2 (masked) change neither the raw status nor the mask.
- R8: Read select 3 (clear) always returns zero.
- R9: `irq_any_o` is high exactly when some bit of the masked status is one. Every bit belongs to one of the five categories.
- R10: `irq_rx_o` follows masked bit 4, `irq_tx_o` masked bit 5 and `irq_rt_o` masked bit 6. `irq_ms_o` is the OR of masked bits 0 to 3. `irq_err_o` is the OR of masked bits 7 to 10.
- R11: The raw status and the mask update on the clock edge that samples the input. The request lines and the read data show that new state one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 11 | Per-bit set pulses from the interrupt sources |
| data_wr_i | input | 1 | Transmit data register write strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 raw, 2 masked, 3 clear |
| wdata_i | input | 11 | Register write data |
| rd_sel_i | input | 2 | Read target, same encoding as the write target |
| rd_data_o | output | 11 | Registered read data |
| irq_any_o | output | 1 | Combined request |
| irq_rx_o | output | 1 | Receive request |
| irq_tx_o | output | 1 | Transmit request |
| irq_rt_o | output | 1 | Receive-timeout request |
| irq_ms_o | output | 1 | Modem-status request |
| irq_err_o | output | 1 | Error request |

## Verification
The bench pulses each of the eleven bits on its own and checks that only the matching category line and the combined line rise. A group decode that is wired to the wrong bits raises the wrong line. A long run of generated steps puts set pulses, clear writes, data writes and mask writes in the same cycles, so a design that gives priority to the clear drops pending bits. Directed steps write the raw and masked selects and read back the clear select. Either leak shows up as corrupted status or as nonzero read data. One step samples a request line before and after the extra pipeline edge. A design with the wrong latency shows the new state too early or too late.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC   = 11;
  localparam int unsigned NUM_LINES = 6;

  localparam int unsigned BIT_RX = 4;
  localparam int unsigned BIT_TX = 5;
  localparam int unsigned BIT_RT = 6;

  localparam logic [NUM_SRC-1:0] GRP_MS  = 11'h00F;
  localparam logic [NUM_SRC-1:0] GRP_RX  = 11'h010;
  localparam logic [NUM_SRC-1:0] GRP_TX  = 11'h020;
  localparam logic [NUM_SRC-1:0] GRP_RT  = 11'h040;
  localparam logic [NUM_SRC-1:0] GRP_ERR = 11'h780;
  localparam logic [NUM_SRC-1:0] GRP_ALL = GRP_MS | GRP_RX | GRP_TX | GRP_RT | GRP_ERR;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLR    = 2'd3
  } reg_sel_e;

  // line index: 0 any, 1 rx, 2 tx, 3 rt, 4 ms, 5 err
  function automatic logic [NUM_SRC-1:0] line_grp(int unsigned idx);
    case (idx)
      0:       return GRP_ALL;
      1:       return GRP_RX;
      2:       return GRP_TX;
      3:       return GRP_RT;
      4:       return GRP_MS;
      default: return GRP_ERR;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_i) | set_i;
  end

  assign raw_o = raw_q;

  // R2 R5
  set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(set_i)) == $past(set_i)));

  // R4
  clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(clr_i & ~set_i)) == '0));

  // R4
  untouched_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((raw_q ^ $past(raw_q)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));

  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = NUM_SRC,
  parameter int unsigned L = NUM_LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [L-1:0] lines_o
);
  logic [W-1:0] pend;
  logic [L-1:0] lines_q;

  assign pend = raw_i & mask_i;

  for (genvar g = 0; g < L; g++) begin : g_line
    localparam logic [W-1:0] Grp = line_grp(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lines_q[g] <= 1'b0;
      else         lines_q[g] <= |(pend & Grp);
    end
  end

  assign lines_o = lines_q;

  // R9
  any_is_union_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lines_q[0] == (|lines_q[L-1:1]));

  // R10
  line_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> (lines_q == '0));
endmodule

// File: rtl/uart_irq_readback.sv
module uart_irq_readback
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0] rd_d, rd_q;

  always_comb begin
    case (sel_i)
      SEL_MASK:   rd_d = mask_i;
      SEL_RAW:    rd_d = raw_i;
      SEL_MASKED: rd_d = raw_i & mask_i;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R8
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_CLR) |=> (rd_q == '0));

  // R6
  masked_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_MASKED) |=> ((rd_q & ~$past(mask_i)) == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic               data_wr_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [1:0]         rd_sel_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_any_o,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_rt_o,
  output logic               irq_ms_o,
  output logic               irq_err_o
);
  logic [NUM_SRC-1:0]   set_vec, clr_vec, raw, mask;
  logic [NUM_LINES-1:0] lines;
  logic                 mask_wr;

  always_comb begin
    set_vec         = src_set_i;
    set_vec[BIT_TX] = src_set_i[BIT_TX] | data_wr_i;
    clr_vec         = (wr_en_i && wr_sel_i == SEL_CLR) ? wdata_i : '0;
    mask_wr         = wr_en_i && wr_sel_i == SEL_MASK;
  end

  uart_irq_status #(.W(NUM_SRC)) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .raw_o  (raw)
  );

  uart_irq_mask #(.W(NUM_SRC)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  uart_irq_route #(.W(NUM_SRC), .L(NUM_LINES)) i_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .mask_i  (mask),
    .lines_o (lines)
  );

  uart_irq_readback #(.W(NUM_SRC)) i_readback (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (rd_sel_i),
    .raw_i     (raw),
    .mask_i    (mask),
    .rd_data_o (rd_data_o)
  );

  assign irq_any_o = lines[0];
  assign irq_rx_o  = lines[1];
  assign irq_tx_o  = lines[2];
  assign irq_rt_o  = lines[3];
  assign irq_ms_o  = lines[4];
  assign irq_err_o = lines[5];

  // R7
  status_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_sel_i == SEL_RAW || wr_sel_i == SEL_MASKED) &&
     src_set_i == '0 && !data_wr_i) |=> ($stable(raw) && $stable(mask)));

  // R3
  data_write_sets_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> raw[BIT_TX]);
endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src_set = '0;
  logic         data_wr = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [1:0]   rd_sel = 2'd1;
  logic [W-1:0] rd_data;
  logic         irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] exp_raw = '0;
  logic [W-1:0] exp_mask = '0;
  logic [31:0]  seed = 32'h1234_5678;

  always #2 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(src_set), .data_wr_i(data_wr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wdata_i(wdata), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_any_o(irq_any), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_rt_o(irq_rt), .irq_ms_o(irq_ms), .irq_err_o(irq_err)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, return at the following negedge
  task automatic apply(input logic [W-1:0] s, input logic dw, input logic we,
                       input logic [1:0] ws, input logic [W-1:0] wd);
    src_set = s; data_wr = dw; wr_en = we; wr_sel = ws; wdata = wd;
    @(negedge clk);
    src_set = '0; data_wr = 1'b0; wr_en = 1'b0;
    if (we && ws == 2'd3) exp_raw = exp_raw & ~wd;
    if (we && ws == 2'd0) exp_mask = wd;
    exp_raw = exp_raw | s;
    if (dw) exp_raw[5] = 1'b1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] val);
    rd_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic check_all(input string ctx);
    logic [W-1:0] v, m;
    logic [5:0] exp_l, act_l;
    m = exp_raw & exp_mask;
    rd(2'd1, v);
    chk({ctx, " R2 raw"}, v, exp_raw);
    exp_l = {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
    act_l = {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_any};
    chk({ctx, " R9 R10 lines"}, {5'd0, act_l}, {5'd0, exp_l});
    rd(2'd2, v);
    chk({ctx, " R6 masked"}, v, m);
    rd(2'd0, v);
    chk({ctx, " R6 mask"}, v, exp_mask);
    rd(2'd3, v);
    chk({ctx, " R8 clear reads zero"}, v, '0);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 lines", {5'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_any}, '0);
    chk("R1 rd_data", rd_data, '0);
    check_all("R1 reset");

    // single-bit sweep with everything enabled
    apply('0, 1'b0, 1'b1, 2'd0, 11'h7FF);
    for (int b = 0; b < W; b++) begin
      apply('0, 1'b0, 1'b1, 2'd3, 11'h7FF);
      apply(11'(1) << b, 1'b0, 1'b0, 2'd0, '0);
      check_all($sformatf("R2 bit%0d", b));
    end

    // R3 data write sets transmit bit
    apply('0, 1'b0, 1'b1, 2'd3, 11'h7FF);
    apply('0, 1'b1, 1'b0, 2'd0, '0);
    check_all("R3 data write");

    // R4 partial clear
    apply(11'h5A5, 1'b0, 1'b0, 2'd0, '0);
    apply('0, 1'b0, 1'b1, 2'd3, 11'h0F0);
    check_all("R4 partial clear");

    // R5 set and clear same cycle
    apply(11'h003, 1'b1, 1'b1, 2'd3, 11'h7FF);
    check_all("R5 set wins");

    // R7 raw/masked writes ignored
    apply(11'h2C1, 1'b0, 1'b0, 2'd0, '0);
    apply('0, 1'b0, 1'b1, 2'd1, 11'h7FF);
    apply('0, 1'b0, 1'b1, 2'd2, 11'h000);
    apply('0, 1'b0, 1'b1, 2'd1, 11'h000);
    check_all("R7 ignored writes");

    // R11 latency: line rises one edge after the raw bit
    apply('0, 1'b0, 1'b1, 2'd3, 11'h7FF);
    apply('0, 1'b0, 1'b1, 2'd0, 11'h7FF);
    check_all("R11 prep");
    apply(11'h010, 1'b0, 1'b0, 2'd0, '0);
    chk("R11 rx before pipeline edge", {10'd0, irq_rx}, '0);
    @(negedge clk);
    chk("R11 rx after pipeline edge", {10'd0, irq_rx}, 11'd1);

    // generated mixed steps
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] s, wd;
      logic dw;
      logic [1:0] ws;
      seed = seed * 32'd1103515245 + 32'd12345;
      s  = seed[26:16] & seed[15:5];
      dw = seed[31];
      seed = seed * 32'd1103515245 + 32'd12345;
      wd = seed[26:16];
      ws = seed[29:28];
      apply(s, dw, seed[30] | seed[31], ws, wd);
      if (k % 3 == 0) check_all($sformatf("R4 R5 R6 mix%0d", k));
    end
    check_all("R6 mix end");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule